// File: doc/BRIEF.md
# Transmit Frame Fetch and Validator

This block sends one Ethernet frame that software has already laid out in memory in its full wire form: a seven-byte run of 0x55, the 0xD5 start delimiter, the frame body and a four-byte check sequence. Software first writes the frame's start address. It then writes the total byte count, and a nonzero count launches the job. The block reads the buffer one byte at a time through a memory read port whose data returns a fixed number of cycles after each request. It checks the count against hard limits and checks the eight leading bytes. Only then does it forward the body on a byte stream, with first-byte and last-byte markers. The delimiter bytes and the check sequence are not forwarded.

A completed job clears the count register and raises a one-cycle transmit interrupt. A rejected job leaves the count register as written, raises no interrupt, and gives a one-cycle error strobe instead. A level input lets software hold the transmit path idle. Computing the check sequence and all line timing belong to other blocks.

The output stream uses valid/ready. A byte moves on a cycle where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the byte and both markers stay unchanged. The sink may hold `m_ready` low for any number of cycles, and no byte is lost or repeated. Memory reads are issued only when a slot is free in the internal buffer, so back-pressure never overruns the buffer.

Top module: `tx_frame_fetch`

## Requirements
- R1: A count write (`cfg_wr_en` high with `cfg_wr_sel` = 1) stores the value in the count register and, if it is nonzero, starts a job. A zero write starts nothing: no reads, no stream, no interrupt and no error.
- R2: If `tx_hold` is high when the count is written, the value is stored but the request is ignored: no stream, no interrupt and no error.
- R3: A count below 64 or above 1530 is rejected before any byte is sent. The limits 64 and 1530 are both accepted.
- R4: Buffer bytes 0 to 6 must equal 0x55 and byte 7 must equal 0xD5. Otherwise the job is rejected and `m_valid` never rises for it.
- R5: An accepted job delivers buffer bytes 8 through count−5 in ascending order, which is count−12 bytes. `m_sop` is high with the first of these bytes and `m_eop` with the last.
- R6: When the last byte has been accepted by the sink, the count register reads 0 on the cycle after that transfer, and `tx_irq` is high for exactly that one cycle.
- R7: A rejected job (R3 or R4) leaves the count register at its written value, raises no interrupt, and pulses `tx_err` for one cycle.
- R8: While `tx_busy` is high, writes to the count register are ignored, and the job in progress finishes unchanged.
- R9: While `m_valid` is high and `m_ready` is low, `m_data`, `m_sop` and `m_eop` hold their values and `m_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Register select: 0 selects the start address, 1 selects the byte count |
| cfg_wr_data | input | WDW (32) | Value to write |
| tx_hold | input | 1 | Holds the transmit path idle; count writes made while it is high start nothing |
| tx_count | output | CW (16) | Current value of the count register |
| mem_rd_en | output | 1 | Byte read request |
| mem_rd_addr | output | AW (16) | Byte address of the request |
| mem_rd_data | input | 8 | Read data, valid RD_LAT cycles after the request |
| m_valid | output | 1 | A stream byte is present |
| m_ready | input | 1 | The sink accepts the byte |
| m_data | output | 8 | Stream byte |
| m_sop | output | 1 | First byte of the frame body |
| m_eop | output | 1 | Last byte of the frame body |
| tx_busy | output | 1 | A job is in progress |
| tx_irq | output | 1 | One-cycle pulse when a job completes |
| tx_err | output | 1 | One-cycle pulse when a job is rejected |

## Verification
A wrong byte index or a wrong end value shows at the stream as `m_sop` or `m_eop` on the wrong byte, or as a byte total that is not count−12, and it shows within the frame that caused it. A read-credit or buffer-occupancy error shows a few cycles after the first stall, once the read latency has passed, as a missing, repeated or changed byte. That is why frames are run with a steady ready, with a ready that drops regularly, and with a ready that is mostly low. A job phase that is stuck or takes the wrong branch shows at once: `tx_busy` never falls, the interrupt or error pulse is missing or doubled, or the count register reads a wrong value after the job.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CHECK = 2'd1,
    PH_SEND  = 2'd2
  } phase_e;

  localparam int          PRE_LEN  = 8;
  localparam int          TAIL_LEN = 4;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
endpackage

// File: rtl/txf_regs.sv
module txf_regs #(
  parameter int AW      = 16,
  parameter int CW      = 16,
  parameter int WDW     = 32,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [WDW-1:0] wr_data,
  input  logic           hold,
  input  logic           busy,
  input  logic           done,
  output logic [AW-1:0]  base_q,
  output logic [CW-1:0]  count_q,
  output logic [CW-1:0]  launch_cnt,
  output logic           launch,
  output logic           len_bad
);
  localparam logic [WDW-1:0] MIN_V = WDW'(MIN_LEN);
  localparam logic [WDW-1:0] MAX_V = WDW'(MAX_LEN);

  logic cnt_wr;
  logic live_req;
  logic in_range;

  assign cnt_wr     = wr_en && wr_sel && !busy;
  assign live_req   = cnt_wr && (wr_data != '0) && !hold;
  assign in_range   = (wr_data >= MIN_V) && (wr_data <= MAX_V);
  assign launch     = live_req && in_range;
  assign len_bad    = live_req && !in_range;
  assign launch_cnt = wr_data[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_en && !wr_sel && !busy) base_q <= wr_data[AW-1:0];
      if (done)        count_q <= '0;
      else if (cnt_wr) count_q <= wr_data[CW-1:0];
    end
  end
endmodule

// File: rtl/txf_reader.sv
module txf_reader #(
  parameter int AW    = 16,
  parameter int LW    = 16,
  parameter int DEPTH = 4,
  parameter int LAT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          hd_valid,
  output logic [7:0]    hd_data,
  input  logic          pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = PW + 1;
  localparam logic [OW:0] DEPTH_V = (OW+1)'(DEPTH);

  logic [AW-1:0]  nxt_addr;
  logic [LW-1:0]  left;
  logic [LAT-1:0] pend;
  logic [7:0]     store [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [OW-1:0]  occ, infl;
  logic           issue, ret;

  assign issue       = (left != '0) && (({1'b0, occ} + {1'b0, infl}) < DEPTH_V);
  assign ret         = pend[LAT-1];
  assign mem_rd_en   = issue;
  assign mem_rd_addr = nxt_addr;
  assign hd_valid    = (occ != '0);
  assign hd_data     = store[rp];

  generate
    if (LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= issue;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= {pend[LAT-2:0], issue};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_addr <= '0;
      left     <= '0;
      wp       <= '0;
      rp       <= '0;
      occ      <= '0;
      infl     <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (start) begin
        nxt_addr <= start_addr;
        left     <= start_len;
      end else if (issue) begin
        nxt_addr <= nxt_addr + AW'(1);
        left     <= left - LW'(1);
      end
      infl <= infl + OW'(issue) - OW'(ret);
      occ  <= occ + OW'(ret) - OW'(pop);
      if (ret) begin
        store[wp] <= mem_rd_data;
        wp        <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      end
      if (pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
    end
  end
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          len_bad,
  input  logic [CW-1:0] launch_cnt,
  input  logic [AW-1:0] base_q,
  input  logic          hd_valid,
  input  logic [7:0]    hd_data,
  output logic          pop,
  output logic          rd_start,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_len,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          err
);
  phase_e        phase;
  logic [AW-1:0] run_base;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] idx;
  logic [CW-1:0] last_idx;
  logic          bad;
  logic [7:0]    exp_b;
  logic          pre_ok, chk_fire, send_last;

  assign last_idx = run_cnt - CW'(PRE_LEN + TAIL_LEN + 1);
  assign exp_b    = (idx == CW'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
  assign pre_ok   = !bad && (hd_data == exp_b);
  assign out_data = hd_data;
  assign busy     = (phase != PH_IDLE);

  always_comb begin
    pop       = 1'b0;
    out_valid = 1'b0;
    chk_fire  = 1'b0;
    send_last = 1'b0;
    case (phase)
      PH_CHECK: begin
        pop      = hd_valid;
        chk_fire = hd_valid && (idx == CW'(PRE_LEN - 1));
      end
      PH_SEND: begin
        out_valid = hd_valid;
        pop       = hd_valid && out_ready;
        send_last = pop && (idx == last_idx);
      end
      default: ;
    endcase
  end

  assign out_sop  = (phase == PH_SEND) && (idx == '0);
  assign out_eop  = (phase == PH_SEND) && (idx == last_idx);
  assign done     = send_last;
  assign rd_start = launch || (chk_fire && pre_ok);
  assign rd_addr  = launch ? base_q : run_base + AW'(PRE_LEN);
  assign rd_len   = launch ? CW'(PRE_LEN) : run_cnt - CW'(PRE_LEN + TAIL_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      run_base <= '0;
      run_cnt  <= '0;
      idx      <= '0;
      bad      <= 1'b0;
      irq      <= 1'b0;
      err      <= 1'b0;
    end else begin
      irq <= send_last;
      err <= len_bad || (chk_fire && !pre_ok);
      case (phase)
        PH_IDLE: begin
          if (launch) begin
            phase    <= PH_CHECK;
            run_base <= base_q;
            run_cnt  <= launch_cnt;
            idx      <= '0;
            bad      <= 1'b0;
          end
        end
        PH_CHECK: begin
          if (pop) begin
            idx <= idx + CW'(1);
            if (hd_data != exp_b) bad <= 1'b1;
          end
          if (chk_fire) begin
            idx   <= '0;
            phase <= pre_ok ? PH_SEND : PH_IDLE;
          end
        end
        PH_SEND: begin
          if (pop) idx <= idx + CW'(1);
          if (send_last) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_fetch.sv
module tx_frame_fetch #(
  parameter int AW      = 16,
  parameter int CW      = 16,
  parameter int WDW     = 32,
  parameter int DEPTH   = 4,
  parameter int RD_LAT  = 2,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_en,
  input  logic           cfg_wr_sel,
  input  logic [WDW-1:0] cfg_wr_data,
  input  logic           tx_hold,
  output logic [CW-1:0]  tx_count,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_rd_addr,
  input  logic [7:0]     mem_rd_data,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [7:0]     m_data,
  output logic           m_sop,
  output logic           m_eop,
  output logic           tx_busy,
  output logic           tx_irq,
  output logic           tx_err
);
  logic [AW-1:0] base_q;
  logic [CW-1:0] launch_cnt;
  logic          launch, len_bad, done;
  logic          hd_valid, pop, rd_start;
  logic [7:0]    hd_data;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] rd_len;

  txf_regs #(
    .AW(AW), .CW(CW), .WDW(WDW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .hold(tx_hold), .busy(tx_busy), .done(done),
    .base_q(base_q), .count_q(tx_count), .launch_cnt(launch_cnt),
    .launch(launch), .len_bad(len_bad)
  );

  txf_reader #(
    .AW(AW), .LW(CW), .DEPTH(DEPTH), .LAT(RD_LAT)
  ) u_reader (
    .clk(clk), .rst_n(rst_n),
    .start(rd_start), .start_addr(rd_addr), .start_len(rd_len),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .hd_valid(hd_valid), .hd_data(hd_data), .pop(pop)
  );

  txf_ctrl #(
    .AW(AW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .len_bad(len_bad), .launch_cnt(launch_cnt), .base_q(base_q),
    .hd_valid(hd_valid), .hd_data(hd_data), .pop(pop),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_len(rd_len),
    .out_ready(m_ready), .out_valid(m_valid), .out_data(m_data),
    .out_sop(m_sop), .out_eop(m_eop),
    .busy(tx_busy), .done(done), .irq(tx_irq), .err(tx_err)
  );
endmodule

// File: rtl/tx_frame_fetch_chk.sv
module tx_frame_fetch_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr_en,
  input logic          cfg_wr_sel,
  input logic [CW-1:0] tx_count,
  input logic          mem_rd_en,
  input logic          m_valid,
  input logic          m_ready,
  input logic [7:0]    m_data,
  input logic          m_sop,
  input logic          m_eop,
  input logic          tx_busy,
  input logic          tx_irq,
  input logic          tx_err
);
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> tx_busy); // R1

  AST_STREAM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> tx_busy); // R5

  AST_MARKERS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(m_sop && m_eop)); // R5

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R6

  AST_IRQ_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_count == '0)); // R6

  AST_ERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_err && tx_irq)); // R7

  AST_ERR_COUNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !(cfg_wr_en && cfg_wr_sel)) |=> $stable(tx_count)); // R7

  AST_BUSY_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> ((tx_count == $past(tx_count)) || (tx_count == '0))); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop))); // R9
endmodule

bind tx_frame_fetch tx_frame_fetch_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
  .tx_count(tx_count), .mem_rd_en(mem_rd_en), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop), .tx_busy(tx_busy),
  .tx_irq(tx_irq), .tx_err(tx_err)
);

// File: tb/tx_frame_fetch_bench.sv
`timescale 1ns/1ps
module tx_frame_fetch_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_sel = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        tx_hold = 1'b0;
  logic [15:0] tx_count;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data;
  logic        m_sop, m_eop;
  logic        tx_busy, tx_irq, tx_err;

  always #4 clk = ~clk;

  tx_frame_fetch #(.RD_LAT(LAT)) u_tx_frame_fetch (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .tx_hold(tx_hold), .tx_count(tx_count),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sop(m_sop),
    .m_eop(m_eop), .tx_busy(tx_busy), .tx_irq(tx_irq), .tx_err(tx_err)
  );

  // memory model with LAT-cycle read latency
  logic [7:0] mem_arr [0:4095];
  logic [7:0] rd_pipe [LAT];
  always @(posedge clk) begin
    rd_pipe[0] <= mem_arr[mem_rd_addr[11:0]];
    for (int k = 1; k < LAT; k++) rd_pipe[k] <= rd_pipe[k-1];
  end
  assign mem_rd_data = rd_pipe[LAT-1];

  // ready pattern
  int ready_pat = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    case (ready_pat)
      1:       m_ready <= (cyc % 3) != 0;
      2:       m_ready <= (cyc % 5) == 0;
      default: m_ready <= 1'b1;
    endcase
  end

  // monitor
  int   nbytes, irqs, errs, marker_bad, eops, stall_bad, busy_cyc, rd_cyc;
  logic [7:0] got [0:2047];
  logic stall_prev = 1'b0;
  logic [7:0] prev_data = '0;
  logic prev_sop = 1'b0, prev_eop = 1'b0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (stall_prev && (!m_valid || m_data != prev_data || m_sop != prev_sop || m_eop != prev_eop))
        stall_bad++;
      if (m_valid && m_ready) begin
        got[nbytes[10:0]] = m_data;
        if (m_sop != (nbytes == 0)) marker_bad++;
        if (m_eop) eops++;
        nbytes++;
      end
      if (tx_irq) irqs++;
      if (tx_err) errs++;
      if (tx_busy) busy_cyc++;
      if (mem_rd_en) rd_cyc++;
      stall_prev = m_valid && !m_ready;
      prev_data  = m_data;
      prev_sop   = m_sop;
      prev_eop   = m_eop;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nbytes = 0; irqs = 0; errs = 0; marker_bad = 0; eops = 0;
    stall_bad = 0; busy_cyc = 0; rd_cyc = 0;
  endtask

  function automatic logic [7:0] body_byte(input int base, input int i);
    return 8'((i * 13 + base) ^ 8'h3C);
  endfunction

  task automatic fill(input int base, input int cnt, input int corrupt_at);
    for (int i = 0; i < cnt; i++) begin
      if (i < 7)       mem_arr[(base + i) % 4096] = 8'h55;
      else if (i == 7) mem_arr[(base + i) % 4096] = 8'hD5;
      else             mem_arr[(base + i) % 4096] = body_byte(base, i);
    end
    if (corrupt_at >= 0) mem_arr[(base + corrupt_at) % 4096] = 8'h54;
  endtask

  task automatic wr(input logic sel, input int val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_event(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irqs + errs > 0) break;
    end
    repeat (6) @(negedge clk);
  endtask

  // accepted frame: full body compare
  task automatic t_good(input int base, input int cnt, input int pat, input string tag);
    int mism = 0;
    fill(base, cnt, -1);
    ready_pat = pat;
    clear_mon();
    wr(1'b0, base);
    wr(1'b1, cnt);
    wait_event(cnt * 8 + 200);
    for (int i = 0; i < cnt - 12 && i < nbytes; i++)
      if (got[i] != body_byte(base, i + 8)) mism++;
    chk({"R5 byte total ", tag}, nbytes, cnt - 12);
    chk({"R5 byte content ", tag}, mism, 0);
    chk({"R5 markers ", tag}, marker_bad + eops, 1);
    chk({"R6 irq ", tag}, irqs, 1);
    chk({"R6 count cleared ", tag}, int'(tx_count), 0);
    chk({"R7 no err ", tag}, errs, 0);
    chk({"R9 stall hold ", tag}, stall_bad, 0);
    ready_pat = 0;
  endtask

  // rejected request
  task automatic t_reject(input int base, input int cnt, input int corrupt_at, input string tag);
    fill(base, (cnt > 2000) ? 2000 : cnt, corrupt_at);
    clear_mon();
    wr(1'b0, base);
    wr(1'b1, cnt);
    wait_event(200);
    chk({"R3/R4 no bytes ", tag}, nbytes, 0);
    chk({"R7 err pulse ", tag}, errs, 1);
    chk({"R7 no irq ", tag}, irqs, 0);
    chk({"R7 count kept ", tag}, int'(tx_count), cnt & 32'hFFFF);
  endtask

  task automatic t_reset();
    chk("R1 reset count", int'(tx_count), 0);
    chk("R1 reset busy", int'(tx_busy), 0);
    chk("R5 reset valid", int'(m_valid), 0);
    chk("R6 reset irq", int'(tx_irq), 0);
  endtask

  task automatic t_zero();
    clear_mon();
    wr(1'b0, 16);
    wr(1'b1, 0);
    repeat (30) @(negedge clk);
    chk("R1 zero busy", busy_cyc, 0);
    chk("R1 zero reads", rd_cyc, 0);
    chk("R1 zero events", nbytes + irqs + errs, 0);
  endtask

  task automatic t_hold();
    fill(300, 100, -1);
    tx_hold = 1'b1;
    clear_mon();
    wr(1'b0, 300);
    wr(1'b1, 100);
    repeat (60) @(negedge clk);
    chk("R2 hold busy", busy_cyc, 0);
    chk("R2 hold events", nbytes + irqs + errs, 0);
    chk("R2 hold stored", int'(tx_count), 100);
    tx_hold = 1'b0;
  endtask

  task automatic t_busy_write();
    fill(600, 80, -1);
    ready_pat = 2;
    clear_mon();
    wr(1'b0, 600);
    wr(1'b1, 80);
    repeat (20) @(negedge clk);
    wr(1'b0, 1200);
    wr(1'b1, 300);
    chk("R8 count frozen", int'(tx_count), 80);
    wait_event(2000);
    chk("R8 bytes unchanged", nbytes, 68);
    chk("R8 first byte", int'(got[0]), int'(body_byte(600, 8)));
    chk("R8 irq once", irqs, 1);
    chk("R8 count cleared", int'(tx_count), 0);
    ready_pat = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem_arr[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_good(40, 64, 0, "min len");
    t_good(200, 100, 1, "ready drops");
    t_good(500, 90, 2, "ready sparse");
    t_good(1000, 1530, 0, "max len");
    t_reject(100, 63, -1, "short R3");
    t_reject(100, 1531, -1, "long R3");
    t_reject(100, 70000, -1, "huge R3");
    t_reject(700, 80, 3, "bad preamble R4");
    t_reject(700, 80, 7, "bad delimiter R4");
    t_hold();
    t_good(300, 100, 0, "after hold R2");
    t_busy_write();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule